// File: doc/BRIEF.md
# DIMM CAS Latency Selector

This block chooses the fastest column-access latency that every installed memory module in a two-slot system can sustain at the current memory bus frequency. For each slot it is given the module's bitmap of supported latencies and two cycle-time bytes: the minimum clock period when the latency is relaxed by half a step, and when it is relaxed by a full step. It is also given the bus frequency in MHz. After a start pulse it converts each cycle-time byte into a module frequency with an iterative divider, uses those results to decide how many latency steps below the slowest supported one the module may use, trims the bitmap accordingly, then merges the two slots.

The slots are handled one after the other by a small controller that shares a single restoring divider. The merged bitmap's lowest set bit is translated into the 3-bit code the memory controller expects. One cycle of `done` delivers the code, or raises `err` when no common latency exists or no module is installed. The result stays on the outputs until the next run finishes.

Top module: `cas_latency_picker`

## Requirements
- R1: After reset `done`, `err` and `cas_code` are all 0.
- R2: A slot whose latency bitmap equals 0xFF is empty and contributes nothing; when exactly one slot is empty the other slot's trimmed bitmap alone decides the result; when both are empty `err` is raised with `done`.
- R3: A cycle-time byte is worth (upper nibble × 10 + lower nibble) tenths of a nanosecond; the module frequency is the integer quotient 20000 / that value, and the byte passes when this quotient is greater than or equal to `bus_mhz` (equality passes).
- R4: A nonzero half-step byte that passes sets the trim step count to 1; a zero half-step byte is not evaluated and leaves the count at 0.
- R5: The full-step byte is evaluated only when the half-step byte passed; when it is nonzero and passes, the count becomes 2; otherwise the count stays where the half-step test left it.
- R6: With h the index of the highest set bit of a slot's bitmap and s the step count, the trimmed bitmap keeps only bits with index ≥ max(h − s, 0).
- R7: When both slots are installed, their trimmed bitmaps are ANDed; an all-zero result raises `err`.
- R8: The lowest set bit index 0,1,2,3,4,5,6,7 of the final bitmap yields `cas_code` 5,5,2,6,3,7,4,0 respectively; the code is never 1.
- R9: `done` is high for exactly one cycle per run; with `err` high `cas_code` is 0; `cas_code` and `err` do not change outside a `done` cycle.
- R10: A `start` pulse that arrives while a run is in progress is ignored and produces neither a second `done` nor a different result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that captures all inputs and begins a run |
| bus_mhz | input | SPEED_W | Memory bus frequency in MHz |
| slot0_cas_map | input | 8 | Slot 0 supported-latency bitmap (0xFF = empty) |
| slot0_cyc_half | input | 8 | Slot 0 cycle time with latency relaxed by half a step |
| slot0_cyc_full | input | 8 | Slot 0 cycle time with latency relaxed by a full step |
| slot1_cas_map | input | 8 | Slot 1 supported-latency bitmap (0xFF = empty) |
| slot1_cyc_half | input | 8 | Slot 1 cycle time with latency relaxed by half a step |
| slot1_cyc_full | input | 8 | Slot 1 cycle time with latency relaxed by a full step |
| cas_code | output | 3 | Selected latency code, held between runs |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | No usable common latency, held between runs |

## Verification
Single-module runs with step counts of 0, 1 and 2 show whether the trim window follows the two frequency tests, including a full-step byte presented behind a zero half-step byte, a quotient exactly equal to the bus frequency, and a step count larger than the highest bit index. Two-module runs with overlapping and disjoint bitmaps separate the intersection from the incompatibility error, and a lone top-bit bitmap shows code 0 apart from an error. Both-empty, back-to-back start and hold-between-runs cases separate the control path from the arithmetic.

// File: rtl/cas_pick_pkg.sv
package cas_pick_pkg;

    localparam int CAS_W   = 8;
    localparam int CYC_W   = 8;
    localparam int CODE_W  = 3;
    localparam int STEP_W  = 2;
    localparam int unsigned TENTHS_MHZ = 20000;

    typedef logic [CAS_W-1:0]  cas_map_t;
    typedef logic [CODE_W-1:0] cas_code_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_WAIT,
        ST_TRIM,
        ST_FIN
    } pick_state_t;

    typedef struct packed {
        cas_map_t            map;
        logic [CYC_W-1:0]    cyc_half;
        logic [CYC_W-1:0]    cyc_full;
    } slot_info_t;

    // Packed period byte to tenths of a nanosecond (max 165).
    function automatic logic [CYC_W-1:0] cyc_to_tenths(logic [CYC_W-1:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

    // Keep bits at or above (top index - step), clamped at bit 0.
    function automatic cas_map_t trim_map(cas_map_t m, step_t s);
        int top;
        int lo;
        top = -1;
        for (int i = 0; i < CAS_W; i++) begin
            if (m[i]) top = i;
        end
        if (top < 0) return '0;
        lo = top - int'(s);
        if (lo < 0) lo = 0;
        return m & cas_map_t'({CAS_W{1'b1}} << lo);
    endfunction

    function automatic int lowest_bit(cas_map_t m);
        int idx;
        idx = 0;
        for (int i = CAS_W - 1; i >= 0; i--) begin
            if (m[i]) idx = i;
        end
        return idx;
    endfunction

    // Controller encoding of the latency chosen by bit position.
    function automatic cas_code_t code_of_bit(int idx);
        case (idx)
            0:       return 3'd5;
            1:       return 3'd5;
            2:       return 3'd2;
            3:       return 3'd6;
            4:       return 3'd3;
            5:       return 3'd7;
            6:       return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/cas_restoring_div.sv
module cas_restoring_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    logic [W:0] trial;
    logic       take;
    logic [W:0] rem_next;

    always_comb begin
        trial    = {rem_q[W-1:0], quo_q[W-1]};
        take     = trial >= {1'b0, dsr_q};
        rem_next = take ? trial - {1'b0, dsr_q} : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dsr_q  <= divisor;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= rem_next;
                quo_q <= {quo_q[W-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

endmodule

// File: rtl/cas_merge.sv
module cas_merge
    import cas_pick_pkg::*;
(
    input  cas_map_t  trim0,
    input  cas_map_t  trim1,
    input  logic      empty0,
    input  logic      empty1,
    output cas_code_t code,
    output logic      fail
);
    cas_map_t joined;

    always_comb begin
        if (empty0 && empty1)  joined = '0;
        else if (empty0)       joined = trim1;
        else if (empty1)       joined = trim0;
        else                   joined = trim0 & trim1;
        fail = (joined == '0);
        code = fail ? '0 : code_of_bit(lowest_bit(joined));
    end

endmodule

// File: rtl/cas_latency_picker.sv
module cas_latency_picker
    import cas_pick_pkg::*;
#(
    parameter int SPEED_W = 16,
    parameter int DIV_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [SPEED_W-1:0] bus_mhz,
    input  logic [7:0]         slot0_cas_map,
    input  logic [7:0]         slot0_cyc_half,
    input  logic [7:0]         slot0_cyc_full,
    input  logic [7:0]         slot1_cas_map,
    input  logic [7:0]         slot1_cyc_half,
    input  logic [7:0]         slot1_cyc_full,
    output logic [2:0]         cas_code,
    output logic               done,
    output logic               err
);
    localparam int NSLOT = 2;
    localparam int CMP_W = (SPEED_W > DIV_W) ? SPEED_W : DIV_W;

    pick_state_t        state_q;
    slot_info_t         info_q  [NSLOT];
    slot_info_t         in_info [NSLOT];
    cas_map_t           trim_q  [NSLOT];
    logic [NSLOT-1:0]   empty_q;
    logic               slot_q;
    logic               phase_q;
    step_t              step_q;
    logic [SPEED_W-1:0] bus_q;

    slot_info_t         cur;
    logic               div_go;
    logic [DIV_W-1:0]   div_den;
    logic               div_done;
    logic [DIV_W-1:0]   div_quo;
    logic               meets;

    cas_code_t          mrg_code;
    logic               mrg_fail;

    assign in_info[0] = '{map: slot0_cas_map, cyc_half: slot0_cyc_half, cyc_full: slot0_cyc_full};
    assign in_info[1] = '{map: slot1_cas_map, cyc_half: slot1_cyc_half, cyc_full: slot1_cyc_full};

    assign cur   = info_q[slot_q];
    assign meets = CMP_W'(div_quo) >= CMP_W'(bus_q);

    always_comb begin
        div_go  = 1'b0;
        div_den = '0;
        case (state_q)
            ST_SLOT: begin
                if (cur.map != '1 && cur.cyc_half != '0) begin
                    div_go  = 1'b1;
                    div_den = DIV_W'(cyc_to_tenths(cur.cyc_half));
                end
            end
            ST_WAIT: begin
                if (div_done && meets && !phase_q && cur.cyc_full != '0) begin
                    div_go  = 1'b1;
                    div_den = DIV_W'(cyc_to_tenths(cur.cyc_full));
                end
            end
            default: ;
        endcase
    end

    cas_restoring_div #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (DIV_W'(TENTHS_MHZ)),
        .divisor  (div_den),
        .done     (div_done),
        .quotient (div_quo)
    );

    cas_merge u_merge (
        .trim0  (trim_q[0]),
        .trim1  (trim_q[1]),
        .empty0 (empty_q[0]),
        .empty1 (empty_q[1]),
        .code   (mrg_code),
        .fail   (mrg_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            for (int i = 0; i < NSLOT; i++) begin
                info_q[i] <= '0;
                trim_q[i] <= '0;
            end
            empty_q  <= '0;
            slot_q   <= 1'b0;
            phase_q  <= 1'b0;
            step_q   <= '0;
            bus_q    <= '0;
            cas_code <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        for (int i = 0; i < NSLOT; i++) info_q[i] <= in_info[i];
                        bus_q   <= bus_mhz;
                        empty_q <= '0;
                        slot_q  <= 1'b0;
                        state_q <= ST_SLOT;
                    end
                end
                ST_SLOT: begin
                    step_q  <= '0;
                    phase_q <= 1'b0;
                    if (cur.map == '1) begin
                        empty_q[slot_q] <= 1'b1;
                        state_q         <= ST_TRIM;
                    end else if (cur.cyc_half == '0) begin
                        state_q <= ST_TRIM;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (div_done) begin
                        if (meets) begin
                            step_q <= phase_q ? step_t'(2) : step_t'(1);
                            if (!phase_q && cur.cyc_full != '0) begin
                                phase_q <= 1'b1;
                            end else begin
                                state_q <= ST_TRIM;
                            end
                        end else begin
                            state_q <= ST_TRIM;
                        end
                    end
                end
                ST_TRIM: begin
                    trim_q[slot_q] <= empty_q[slot_q] ? '0 : trim_map(cur.map, step_q);
                    if (slot_q) begin
                        state_q <= ST_FIN;
                    end else begin
                        slot_q  <= 1'b1;
                        state_q <= ST_SLOT;
                    end
                end
                ST_FIN: begin
                    done     <= 1'b1;
                    cas_code <= mrg_code;
                    err      <= mrg_fail;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cas_latency_picker_chk.sv
module cas_latency_picker_chk (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic       err,
    input logic [2:0] cas_code,
    input logic [7:0] map0_q,
    input logic [7:0] map1_q
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    err_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (cas_code == 3'd0));

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(cas_code) && $stable(err)));

    // R8
    code_never_one_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cas_code != 3'd1));

    // R2
    both_empty_err_chk: assert property (@(posedge clk) disable iff (rst)
        (done && map0_q == 8'hFF && map1_q == 8'hFF) |-> err);

endmodule

bind cas_latency_picker cas_latency_picker_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .err      (err),
    .cas_code (cas_code),
    .map0_q   (info_q[0].map),
    .map1_q   (info_q[1].map)
);

// File: tb/cas_latency_picker_bench.sv
module cas_latency_picker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] bus_mhz = '0;
    logic [7:0]  m0 = '0, h0 = '0, f0 = '0;
    logic [7:0]  m1 = '0, h1 = '0, f1 = '0;
    logic [2:0]  cas_code;
    logic        done;
    logic        err;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cas_latency_picker u_cas_latency_picker (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .bus_mhz        (bus_mhz),
        .slot0_cas_map  (m0),
        .slot0_cyc_half (h0),
        .slot0_cyc_full (f0),
        .slot1_cas_map  (m1),
        .slot1_cyc_half (h1),
        .slot1_cyc_full (f1),
        .cas_code       (cas_code),
        .done           (done),
        .err            (err)
    );

    task automatic check_val(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary_and_end();
    end

    task automatic load(input logic [15:0] bus,
                        input logic [7:0] a0, input logic [7:0] b0, input logic [7:0] c0,
                        input logic [7:0] a1, input logic [7:0] b1, input logic [7:0] c1);
        bus_mhz = bus;
        m0 = a0; h0 = b0; f0 = c0;
        m1 = a1; h1 = b1; f1 = c1;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Waits for done (sampled at negedge), then checks results and one-cycle width.
    task automatic await_and_check(string req, int exp_code, int exp_err);
        int n;
        n = 0;
        while (!done && n < WAIT_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check_val({req, " done seen"}, int'(done), 1);
        check_val({req, " code"}, int'(cas_code), exp_code);
        check_val({req, " err"}, int'(err), exp_err);
        @(negedge clk);
        check_val("R9 done width", int'(done), 0);
    endtask

    task automatic run_pick(string req, int exp_code, int exp_err);
        pulse_start();
        await_and_check(req, exp_code, exp_err);
    endtask

    task automatic t_reset();
        check_val("R1 done", int'(done), 0);
        check_val("R1 err", int'(err), 0);
        check_val("R1 code", int'(cas_code), 0);
    endtask

    // 0x1C bits 4..2; half 0x60 -> 333 MHz, full 0x75 -> 266 MHz, bus 200: two steps.
    task automatic t_two_steps();
        load(16'd200, 8'h1C, 8'h60, 8'h75, 8'hFF, 8'h00, 8'h00);
        run_pick("R5 two steps slot1 empty R2", 2, 0);
    endtask

    // half 0xB0 -> 181 MHz below 200: no trim step, keep bit 4 -> code 3.
    task automatic t_half_fails();
        load(16'd200, 8'h1C, 8'hB0, 8'h50, 8'hFF, 8'h00, 8'h00);
        run_pick("R4 half fails R3", 3, 0);
    endtask

    // zero half byte, full byte ignored even though fast.
    task automatic t_zero_half();
        load(16'd200, 8'h1C, 8'h00, 8'h50, 8'hFF, 8'h00, 8'h00);
        run_pick("R5 full unchecked behind zero half R4", 3, 0);
    endtask

    // 0xA0 -> exactly 200 MHz passes; map 0x06 step 1 keeps bits 2,1 -> bit1 -> code 5.
    task automatic t_equal_speed();
        load(16'd200, 8'h06, 8'hA0, 8'h00, 8'hFF, 8'h00, 8'h00);
        run_pick("R3 equality passes", 5, 0);
    endtask

    // bit 3 alone with step 1 at bus 201 fails -> bit3 -> code 6 (equality boundary other side).
    task automatic t_just_below();
        load(16'd201, 8'h0C, 8'hA0, 8'h00, 8'hFF, 8'h00, 8'h00);
        run_pick("R3 one MHz above fails", 6, 0);
    endtask

    // step 2 larger than top index 0 -> clamp, bit0 -> code 5.
    task automatic t_clamp();
        load(16'd100, 8'h01, 8'h50, 8'h50, 8'hFF, 8'h00, 8'h00);
        run_pick("R6 clamp at bit0", 5, 0);
    endtask

    // slot0 step1 (0x75 passes, 0xB0 fails) -> 0x18; slot1 0x0C step0 -> 0x08; AND 0x08 -> code 6.
    task automatic t_intersect();
        load(16'd200, 8'h1C, 8'h75, 8'hB0, 8'h0C, 8'h00, 8'h00);
        run_pick("R7 intersection", 6, 0);
    endtask

    // disjoint bitmaps -> error, then held for several cycles.
    task automatic t_disjoint();
        load(16'd200, 8'h10, 8'h00, 8'h00, 8'h04, 8'h00, 8'h00);
        run_pick("R7 disjoint error", 0, 1);
        repeat (5) @(negedge clk);
        check_val("R9 err held", int'(err), 1);
        check_val("R9 code held", int'(cas_code), 0);
    endtask

    task automatic t_both_empty();
        load(16'd200, 8'hFF, 8'h50, 8'h50, 8'hFF, 8'h50, 8'h50);
        run_pick("R2 both empty", 0, 1);
    endtask

    // slot0 empty, slot1 top bit only -> index 7 -> code 0 without error.
    task automatic t_top_bit();
        load(16'd200, 8'hFF, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
        run_pick("R8 bit7 code0 R2", 0, 0);
    endtask

    // table walk over single-bit bitmaps with no trimming.
    task automatic t_table();
        int exp_tab [8] = '{5, 5, 2, 6, 3, 7, 4, 0};
        for (int i = 0; i < 8; i++) begin
            load(16'd200, 8'(1 << i), 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00);
            run_pick("R8 table", exp_tab[i], 0);
        end
    endtask

    // second start during a run changes nothing.
    task automatic t_busy_start();
        int extra;
        load(16'd200, 8'h1C, 8'h60, 8'h75, 8'hFF, 8'h00, 8'h00);
        pulse_start();
        load(16'd200, 8'h10, 8'h00, 8'h00, 8'h04, 8'h00, 8'h00);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        await_and_check("R10 start while busy", 2, 0);
        extra = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check_val("R10 no second done", extra, 0);
        check_val("R10 code kept", int'(cas_code), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_two_steps();
        t_half_fails();
        t_zero_half();
        t_equal_speed();
        t_just_below();
        t_clamp();
        t_intersect();
        t_disjoint();
        t_both_empty();
        t_top_bit();
        t_table();
        t_busy_start();
        summary_and_end();
    end

endmodule